// File: doc/BRIEF.md
# I2C Bus Recovery Sequencer

This block frees an I2C bus that a slave has left stuck, for example one that was interrupted mid-byte and still holds SDA low. After a start strobe it looks at the synchronized SCL and SDA levels. If both lines already read high, it reports success at once and touches nothing. Otherwise it takes the pins away from the normal controller through a mux-select output. It then clocks SCL in open-drain fashion, pulling it low and releasing it, for a number of pulses that follows the largest packet the slave may send. SDA is never driven.

After the last pulse the sequencer waits for both lines to read high. If they do not go high within a timeout, it ends with a bus-busy error. On either outcome the pins go back to the normal controller, and sticky done and error flags report the result until the next accepted start. Both phase lengths come from a clock-frequency parameter and interval parameters given in microseconds, so a bench can shorten them.

Top module: `i2c_bus_recovery`

## Requirements
- R1: While reset is applied and after it is released, scl_drive_low_o, pin_sel_o, done_o and err_busy_o are all 0.
- R2: If both synchronized lines read high when a start is accepted, done_o is 1 and err_busy_o is 0 in the next cycle. No SCL pulse is produced and pin_sel_o stays 0.
- R3: With max_bytes_i equal to 0, exactly 9 SCL low pulses are produced.
- R4: With a nonzero max_bytes_i value N, exactly N*8+1 SCL low pulses are produced.
- R5: Each SCL low phase lasts HALF_CYC = CLK_HZ/1e6*HALF_US clock cycles, and each released phase between two pulses lasts HALF_CYC cycles.
- R6: After the last pulse, the wait ends in the first cycle in which both synchronized lines read high, with done_o=1 and err_busy_o=0. If both lines are already high when the wait begins, pin_sel_o is high for exactly P*2*HALF_CYC+1 cycles, where P is the pulse count.
- R7: If the lines do not both read high within TIMEOUT_CYC = CLK_HZ/1e6*TIMEOUT_US cycles of waiting, the block ends with done_o=1 and err_busy_o=1. pin_sel_o is then high for exactly P*2*HALF_CYC+TIMEOUT_CYC cycles.
- R8: pin_sel_o rises in the cycle after an accepted start, and falls in the same cycle in which done_o rises, on success and on error alike. scl_drive_low_o is high only while pin_sel_o is high.
- R9: A start strobe during a recovery has no effect on the pulse count, the timing or the result. An accepted start clears done_o and err_busy_o in the next cycle unless the lines were already high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe, accepted only while idle |
| max_bytes_i | input | BYTE_W | Largest slave packet in bytes; 0 selects 9 pulses |
| scl_in_i | input | 1 | Raw SCL line level |
| sda_in_i | input | 1 | Raw SDA line level |
| scl_drive_low_o | output | 1 | 1 pulls SCL low (open-drain enable) |
| pin_sel_o | output | 1 | 1 hands the pins to the sequencer instead of the controller |
| done_o | output | 1 | Sticky: recovery finished |
| err_busy_o | output | 1 | Sticky: lines did not go high before the timeout |

## Verification
A wrong pulse counter shows up on scl_drive_low_o as a pulse count other than 9 or N*8+1 as soon as the pulse train ends. A wrong phase timer shows up as a low or released phase whose width differs from HALF_CYC within the first pulse. A state machine that leaves the wait state at the wrong time makes pin_sel_o high for the wrong number of cycles, or sets err_busy_o wrongly, at the end of the same recovery. A start strobe that wrongly restarts a recovery shows up as extra pulses within one pulse period.

// File: rtl/busrec_pkg.sv
package busrec_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOW  = 2'd1,
        ST_REL  = 2'd2,
        ST_WAIT = 2'd3
    } rec_state_e;

    localparam int DEFAULT_PULSES = 9;

endpackage

// File: rtl/busrec_sync.sv
module busrec_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw_i,
    output logic [WIDTH-1:0] sync_o
);

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain_d, chain_q;

        always_comb begin
            chain_d = {chain_q[STAGES-2:0], raw_i[b]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '1;
            else        chain_q <= chain_d;
        end

        assign sync_o[b] = chain_q[STAGES-1];
    end

endmodule

// File: rtl/busrec_timer.sv
module busrec_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    output logic [TW-1:0] cnt_o
);

    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (clr_i)            cnt_d = '0;
        else if (&cnt_q)      cnt_d = cnt_q;
        else                  cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/busrec_ctrl.sv
module busrec_ctrl
    import busrec_pkg::*;
#(
    parameter int BYTE_W      = 4,
    parameter int CNT_W       = 8,
    parameter int TW          = 8,
    parameter int HALF_CYC    = 50,
    parameter int TIMEOUT_CYC = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [BYTE_W-1:0] max_bytes_i,
    input  logic              scl_s_i,
    input  logic              sda_s_i,
    input  logic [TW-1:0]     tmr_i,
    output logic              tmr_clr_o,
    output logic              scl_drive_low_o,
    output logic              pin_sel_o,
    output logic              done_o,
    output logic              err_busy_o
);

    localparam logic [TW-1:0] HALF_LAST = TW'(HALF_CYC - 1);
    localparam logic [TW-1:0] TMO_LAST  = TW'(TIMEOUT_CYC - 1);

    typedef struct packed {
        rec_state_e       state;
        logic [CNT_W-1:0] left;
        logic             done;
        logic             err;
    } ctrl_regs_t;

    ctrl_regs_t r_d, r_q;
    logic       lines_high;
    logic [CNT_W-1:0] pulse_target;

    assign lines_high = scl_s_i & sda_s_i;

    always_comb begin
        if (max_bytes_i == '0) pulse_target = CNT_W'(DEFAULT_PULSES);
        else                   pulse_target = (CNT_W'(max_bytes_i) << 3) + 1'b1;
    end

    always_comb begin
        r_d       = r_q;
        tmr_clr_o = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                tmr_clr_o = 1'b1;
                if (start_i) begin
                    r_d.err = 1'b0;
                    if (lines_high) begin
                        r_d.done = 1'b1;
                    end else begin
                        r_d.done  = 1'b0;
                        r_d.state = ST_LOW;
                        r_d.left  = pulse_target;
                    end
                end
            end
            ST_LOW: begin
                if (tmr_i == HALF_LAST) begin
                    tmr_clr_o = 1'b1;
                    r_d.state = ST_REL;
                end
            end
            ST_REL: begin
                if (tmr_i == HALF_LAST) begin
                    tmr_clr_o = 1'b1;
                    r_d.left  = r_q.left - 1'b1;
                    r_d.state = (r_q.left == CNT_W'(1)) ? ST_WAIT : ST_LOW;
                end
            end
            ST_WAIT: begin
                if (lines_high) begin
                    r_d.state = ST_IDLE;
                    r_d.done  = 1'b1;
                end else if (tmr_i == TMO_LAST) begin
                    r_d.state = ST_IDLE;
                    r_d.done  = 1'b1;
                    r_d.err   = 1'b1;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{state: ST_IDLE, left: '0, done: 1'b0, err: 1'b0};
        else        r_q <= r_d;
    end

    assign scl_drive_low_o = (r_q.state == ST_LOW);
    assign pin_sel_o       = (r_q.state != ST_IDLE);
    assign done_o          = r_q.done;
    assign err_busy_o      = r_q.err;

endmodule

// File: rtl/i2c_bus_recovery.sv
module i2c_bus_recovery #(
    parameter int CLK_HZ     = 50_000_000,
    parameter int HALF_US    = 50,
    parameter int TIMEOUT_US = 200_000,
    parameter int BYTE_W     = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [BYTE_W-1:0] max_bytes_i,
    input  logic              scl_in_i,
    input  logic              sda_in_i,
    output logic              scl_drive_low_o,
    output logic              pin_sel_o,
    output logic              done_o,
    output logic              err_busy_o
);

    localparam int CYC_PER_US  = CLK_HZ / 1_000_000;
    localparam int HALF_CYC    = CYC_PER_US * HALF_US;
    localparam int TIMEOUT_CYC = CYC_PER_US * TIMEOUT_US;
    localparam int LONGEST     = (HALF_CYC > TIMEOUT_CYC) ? HALF_CYC : TIMEOUT_CYC;
    localparam int TW          = $clog2(LONGEST + 1);
    localparam int CNT_W       = BYTE_W + 4;

    logic [1:0]    lines_s;
    logic          tmr_clr;
    logic [TW-1:0] tmr_cnt;

    busrec_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  ({scl_in_i, sda_in_i}),
        .sync_o (lines_s)
    );

    busrec_timer #(.TW(TW)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (tmr_clr),
        .cnt_o (tmr_cnt)
    );

    busrec_ctrl #(
        .BYTE_W      (BYTE_W),
        .CNT_W       (CNT_W),
        .TW          (TW),
        .HALF_CYC    (HALF_CYC),
        .TIMEOUT_CYC (TIMEOUT_CYC)
    ) u_ctrl (
        .clk             (clk),
        .rst_n           (rst_n),
        .start_i         (start_i),
        .max_bytes_i     (max_bytes_i),
        .scl_s_i         (lines_s[1]),
        .sda_s_i         (lines_s[0]),
        .tmr_i           (tmr_cnt),
        .tmr_clr_o       (tmr_clr),
        .scl_drive_low_o (scl_drive_low_o),
        .pin_sel_o       (pin_sel_o),
        .done_o          (done_o),
        .err_busy_o      (err_busy_o)
    );

endmodule

// File: rtl/busrec_chk.sv
module busrec_chk #(
    parameter int HALF_CYC = 50
) (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic scl_drive_low_o,
    input logic pin_sel_o,
    input logic done_o,
    input logic err_busy_o
);

    int low_run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               low_run_q <= 0;
        else if (scl_drive_low_o) low_run_q <= low_run_q + 1;
        else                      low_run_q <= 0;
    end

    // R1
    always_comb begin
        if (!rst_n) begin
            reset_quiet_chk: assert (!scl_drive_low_o && !pin_sel_o && !done_o && !err_busy_o);
        end
    end

    // R8
    drive_only_when_owned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scl_drive_low_o |-> pin_sel_o);

    // R8
    release_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pin_sel_o) |-> done_o);

    // R8
    takeover_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pin_sel_o) |-> $past(start_i));

    // R9
    no_done_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pin_sel_o |-> !done_o);

    // R7
    err_implies_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_busy_o |-> done_o);

    // R5
    low_phase_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(scl_drive_low_o) |-> (low_run_q == HALF_CYC));

endmodule

bind i2c_bus_recovery busrec_chk #(.HALF_CYC(HALF_CYC)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .start_i         (start_i),
    .scl_drive_low_o (scl_drive_low_o),
    .pin_sel_o       (pin_sel_o),
    .done_o          (done_o),
    .err_busy_o      (err_busy_o)
);

// File: tb/i2c_bus_recovery_bench.sv
`timescale 1ns/1ps
module i2c_bus_recovery_bench;

    localparam int CLK_HZ     = 20_000_000;
    localparam int HALF_US    = 1;
    localparam int TIMEOUT_US = 25;
    localparam int BYTE_W     = 4;
    localparam int H          = (CLK_HZ / 1_000_000) * HALF_US;
    localparam int T          = (CLK_HZ / 1_000_000) * TIMEOUT_US;
    localparam int LIMIT      = 20000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic [BYTE_W-1:0] max_bytes_i = '0;
    logic              sda_stuck = 1'b0;
    logic              scl_in_i, sda_in_i;
    logic              scl_drive_low_o, pin_sel_o, done_o, err_busy_o;

    int vectors = 0;
    int misses  = 0;

    always #10 clk = ~clk;

    assign scl_in_i = ~scl_drive_low_o;
    assign sda_in_i = ~sda_stuck;

    i2c_bus_recovery #(
        .CLK_HZ(CLK_HZ), .HALF_US(HALF_US), .TIMEOUT_US(TIMEOUT_US), .BYTE_W(BYTE_W)
    ) u_i2c_bus_recovery (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .max_bytes_i(max_bytes_i),
        .scl_in_i(scl_in_i), .sda_in_i(sda_in_i),
        .scl_drive_low_o(scl_drive_low_o), .pin_sel_o(pin_sel_o),
        .done_o(done_o), .err_busy_o(err_busy_o)
    );

    function automatic int exp_pulses(input int n);
        return (n == 0) ? 9 : n * 8 + 1;
    endfunction

    function automatic int exp_busy(input int n, input bool_never);
        return exp_pulses(n) * 2 * H + (bool_never ? T : 1);
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        vectors++;
        if (!ok) begin
            misses++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    // mode: 0 lines idle, 1 never released, 2 released after k rising edges
    task automatic trial(input int n, input int mode, input int k, input bit inject);
        int pulses = 0, busy = 0, lw = 0, hw = 0, bad_lw = 0, bad_hw = 0, rises = 0;
        bit prev_low = 0, fin = 0, first = 1, inj_on = 0;
        max_bytes_i = BYTE_W'(n);
        sda_stuck   = (mode != 0);
        repeat (4) @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int cyc = 0; cyc < LIMIT && !fin; cyc++) begin
            if (inj_on) begin start_i = 1'b0; inj_on = 0; end
            if (first) begin
                if (mode == 0) chk(done_o == 1'b1 && err_busy_o == 1'b0, "R2 done at once", int'(done_o), 1);
                else           chk(done_o == 1'b0 && err_busy_o == 1'b0, "R9 flags cleared", int'(done_o), 0);
                if (mode != 0) chk(pin_sel_o == 1'b1, "R8 takeover", int'(pin_sel_o), 1);
                first = 0;
            end
            if (pin_sel_o) busy++;
            if (scl_drive_low_o) begin
                if (!prev_low) begin
                    if (pulses > 0 && hw != H) bad_hw++;
                    pulses++;
                end
                lw++;
                hw = 0;
            end else begin
                if (prev_low) begin
                    if (lw != H) bad_lw++;
                    rises++;
                    if (mode == 2 && rises == k) sda_stuck = 1'b0;
                end
                lw = 0;
                if (pin_sel_o) hw++;
            end
            prev_low = scl_drive_low_o;
            if (inject && busy == 5) begin start_i = 1'b1; inj_on = 1; end
            if (done_o) fin = 1;
            else @(negedge clk);
        end
        start_i = 1'b0;
        chk(fin, "R6 finished", int'(fin), 1);
        chk(pin_sel_o == 1'b0, "R8 pins returned", int'(pin_sel_o), 0);
        if (mode == 0) begin
            chk(pulses == 0, "R2 no pulses", pulses, 0);
            chk(busy == 0, "R2 no takeover", busy, 0);
        end else begin
            if (n == 0) chk(pulses == exp_pulses(n), "R3 pulse count", pulses, exp_pulses(n));
            else        chk(pulses == exp_pulses(n), "R4 pulse count", pulses, exp_pulses(n));
            chk(bad_lw == 0, "R5 low widths", bad_lw, 0);
            chk(bad_hw == 0, "R5 high widths", bad_hw, 0);
            if (mode == 1) begin
                chk(err_busy_o == 1'b1, "R7 busy error", int'(err_busy_o), 1);
                chk(busy == exp_busy(n, 1), "R7 busy cycles", busy, exp_busy(n, 1));
            end else begin
                chk(err_busy_o == 1'b0, "R6 success", int'(err_busy_o), 0);
                chk(busy == exp_busy(n, 0), "R6 busy cycles", busy, exp_busy(n, 0));
            end
            if (inject) chk(pulses == exp_pulses(n), "R9 start ignored", pulses, exp_pulses(n));
        end
    endtask

    initial begin
        #(200000 * 20);
        misses++;
        $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        chk(!scl_drive_low_o && !pin_sel_o && !done_o && !err_busy_o, "R1 reset outputs",
            int'({scl_drive_low_o, pin_sel_o, done_o, err_busy_o}), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!scl_drive_low_o && !pin_sel_o && !done_o && !err_busy_o, "R1 after reset",
            int'({scl_drive_low_o, pin_sel_o, done_o, err_busy_o}), 0);

        trial(0, 0, 0, 0);
        trial(0, 2, 9, 0);
        trial(0, 1, 0, 0);
        trial(1, 2, 3, 0);
        trial(15, 2, 121, 0);
        trial(2, 1, 0, 1);
        trial(3, 2, 25, 1);
        trial(0, 0, 0, 0);

        for (int i = 0; i < 16; i++) begin
            int n = int'($urandom % 16);
            int m = int'($urandom % 3);
            int k = 1 + int'($urandom % exp_pulses(n));
            bit inj = (m != 0) && ($urandom % 3 == 0);
            trial(n, m, k, inj);
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule